// File: doc/BRIEF.md
# Transmit Event Queue with Watermark and Index Acknowledge

After a frame has left the node, the transmit path hands this block one event: the message identifier, a timestamp and the marker of the buffer that sent it. The block files each event into a circular store whose depth is set at run time, up to a build-time maximum. The host reads the oldest pending event from a set of registered read outputs. It also gets an element address formed from a configurable base. The host frees elements by writing the index of the last one it has consumed. Every element up to and including that index is released at once.

The block reports how many elements are pending and whether the store is full. Three sticky interrupt flags signal the store becoming full, the fill level reaching a configured watermark, and an event lost because no room was left. The host clears each flag by writing a one to its bit. Configuration inputs are meant to stay constant outside reset.

Top module: `txev_fifo`

## Requirements
- R1: An accepted event's identifier, timestamp and marker are stored at the put index. Whenever the fill level is nonzero, rd_id, rd_ts and rd_mark show the element at the get index.
- R2: The effective depth is cfg_depth, with 0 treated as 1 and values above MAX_DEPTH treated as MAX_DEPTH. The put and get indices wrap to 0 after effective depth minus one.
- R3: fill never exceeds the effective depth, and full is high exactly when fill equals the effective depth.
- R4: An event arriving while the store is full is discarded and sets irq_lost. This holds even if an acknowledge is written in the same cycle. fill and the stored contents are unchanged by it.
- R5: An acknowledge of index a, with k = (a - get_idx) modulo the effective depth, sets get_idx to (a + 1) modulo the effective depth. It lowers fill by k + 1.
- R6: An acknowledge is ignored when a is not below the effective depth, or when k is not below fill.
- R7: An accepted event and a valid acknowledge in the same cycle are both applied: fill changes by 1 - (k + 1).
- R8: irq_full is set in the cycle fill becomes equal to the effective depth.
- R9: irq_wmark is set when fill rises from below cfg_wmark to cfg_wmark or above. A watermark of 0 or above the effective depth never sets it.
- R10: The flags are sticky. With clr_valid high, a one in clr_mask clears its flag: bit 0 is irq_full, bit 1 is irq_wmark, bit 2 is irq_lost. A set in the same cycle wins over the clear.
- R11: rd_addr equals cfg_start plus two times get_idx, using the cfg_start sampled at the same clock edge that produced get_idx.
- R12: While rst is high, fill and get_idx are 0, full and all flags are 0, and rd_addr equals cfg_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | CNT_W | Configured depth in elements |
| cfg_wmark | input | CNT_W | Watermark fill level, 0 disables |
| cfg_start | input | ADDR_W | Base address of the element area |
| ev_valid | input | 1 | Transmit event strobe |
| ev_id | input | ID_W | Message identifier of the sent frame |
| ev_ts | input | TS_W | Timestamp of the sent frame |
| ev_mark | input | MK_W | Marker copied from the sending buffer |
| ack_valid | input | 1 | Acknowledge index write strobe |
| ack_idx | input | IDX_W | Index of the last consumed element |
| clr_valid | input | 1 | Flag clear write strobe |
| clr_mask | input | 3 | Write-one-to-clear mask for the flags |
| rd_id | output | ID_W | Identifier at the get index |
| rd_ts | output | TS_W | Timestamp at the get index |
| rd_mark | output | MK_W | Marker at the get index |
| rd_addr | output | ADDR_W | Start address plus twice the get index |
| fill | output | CNT_W | Number of pending elements |
| get_idx | output | IDX_W | Index of the oldest pending element |
| full | output | 1 | Fill equals effective depth |
| irq_full | output | 1 | Sticky full interrupt flag |
| irq_wmark | output | 1 | Sticky watermark interrupt flag |
| irq_lost | output | 1 | Sticky event-lost interrupt flag |

## Verification
Every output is a register loaded at the same edge that samples the event, acknowledge, clear and start-address inputs. So each result is due exactly one clock after its stimulus, and reading the newly written element needs no extra cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and updates its arithmetic model of indices, fill and flags for that edge. It then compares all outputs on the following falling edge. The stored data is compared only while fill is nonzero, and a clear that meets a new set in the same edge is expected to leave the flag set.

// File: rtl/txev_pkg.sv
package txev_pkg;

  typedef enum int {
    FLG_FULL  = 0,
    FLG_WMARK = 1,
    FLG_LOST  = 2
  } flag_pos_e;

  localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/txev_index_ctrl.sv
module txev_index_ctrl #(
  parameter int MAX_DEPTH = 32,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] depth_e,
  input  logic             ev_valid,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [IDX_W-1:0] get_q,
  output logic [IDX_W-1:0] get_n,
  output logic [CNT_W-1:0] fill_q,
  output logic [CNT_W-1:0] fill_n,
  output logic             full_q,
  output logic             drop
);

  localparam int SUM_W = CNT_W + 1;

  logic [IDX_W-1:0] put_q, put_n;
  logic [SUM_W-1:0] ax, gx, dx, fx, px, k, ax1, px1, freed, fsum;
  logic             ack_ok, wr_ok;

  always_comb begin
    ax  = SUM_W'(ack_idx);
    gx  = SUM_W'(get_q);
    dx  = SUM_W'(depth_e);
    fx  = SUM_W'(fill_q);
    px  = SUM_W'(put_q);
    // distance from the oldest element to the acknowledged one, modulo depth
    if (ax >= gx) k = ax - gx;
    else          k = ax + dx - gx;
    ack_ok = ack_valid && (ax < dx) && (k < fx);
    freed  = ack_ok ? k + SUM_W'(1) : '0;
    ax1    = ax + SUM_W'(1);
    if (!ack_ok)        get_n = get_q;
    else if (ax1 == dx) get_n = {IDX_W{1'b0}};
    else                get_n = IDX_W'(ax1);
    // room is judged on the fill held before this edge
    wr_ok  = ev_valid && (fill_q < depth_e);
    px1    = px + SUM_W'(1);
    if (!wr_ok)         put_n = put_q;
    else if (px1 == dx) put_n = {IDX_W{1'b0}};
    else                put_n = IDX_W'(px1);
    fsum   = fx + SUM_W'(wr_ok) - freed;
    fill_n = CNT_W'(fsum);
  end

  assign wr_en   = wr_ok;
  assign wr_addr = put_q;
  assign drop    = ev_valid && !wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      get_q  <= '0;
      put_q  <= '0;
      fill_q <= '0;
      full_q <= 1'b0;
    end else begin
      get_q  <= get_n;
      put_q  <= put_n;
      fill_q <= fill_n;
      full_q <= (fill_n == depth_e);
    end
  end

endmodule

// File: rtl/txev_store.sv
module txev_store #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5,
  parameter int DW    = 53
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic          collide;

  assign collide = we && (waddr == raddr);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read register with write-first forwarding kept outside the array
  always_ff @(posedge clk) begin
    if (collide) rdata <= wdata;
    else         rdata <= mem[raddr];
  end

endmodule

// File: rtl/txev_irq.sv
module txev_irq
  import txev_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     depth_e,
  input  logic [CNT_W-1:0]     wmark,
  input  logic [CNT_W-1:0]     fill_q,
  input  logic [CNT_W-1:0]     fill_n,
  input  logic                 drop,
  input  logic                 clr_valid,
  input  logic [NUM_FLAGS-1:0] clr_mask,
  output logic [NUM_FLAGS-1:0] flags
);

  logic [NUM_FLAGS-1:0] set_v, clr_v;
  logic                 wm_on;

  always_comb begin
    wm_on            = (wmark != '0) && (wmark <= depth_e);
    set_v            = '0;
    set_v[FLG_FULL]  = (fill_n == depth_e) && (fill_q != depth_e);
    set_v[FLG_WMARK] = wm_on && (fill_q < wmark) && (fill_n >= wmark);
    set_v[FLG_LOST]  = drop;
    clr_v            = clr_valid ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= set_v | (flags & ~clr_v);
  end

endmodule

// File: rtl/txev_fifo.sv
module txev_fifo
  import txev_pkg::*;
#(
  parameter int MAX_DEPTH = 32,
  parameter int ID_W      = 29,
  parameter int TS_W      = 16,
  parameter int MK_W      = 8,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_depth,
  input  logic [CNT_W-1:0]  cfg_wmark,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic              ev_valid,
  input  logic [ID_W-1:0]   ev_id,
  input  logic [TS_W-1:0]   ev_ts,
  input  logic [MK_W-1:0]   ev_mark,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  input  logic              clr_valid,
  input  logic [2:0]        clr_mask,
  output logic [ID_W-1:0]   rd_id,
  output logic [TS_W-1:0]   rd_ts,
  output logic [MK_W-1:0]   rd_mark,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  fill,
  output logic [IDX_W-1:0]  get_idx,
  output logic              full,
  output logic              irq_full,
  output logic              irq_wmark,
  output logic              irq_lost
);

  localparam int DW = ID_W + TS_W + MK_W;

  logic [CNT_W-1:0]     depth_e;
  logic                 wr_en, drop;
  logic [IDX_W-1:0]     wr_addr, get_n;
  logic [CNT_W-1:0]     fill_n;
  logic [DW-1:0]        rdata;
  logic [NUM_FLAGS-1:0] flags;

  // clamp the run-time depth into 1..MAX_DEPTH
  always_comb begin
    if (cfg_depth == '0)                        depth_e = CNT_W'(1);
    else if (cfg_depth > CNT_W'(MAX_DEPTH))     depth_e = CNT_W'(MAX_DEPTH);
    else                                        depth_e = cfg_depth;
  end

  txev_index_ctrl #(
    .MAX_DEPTH (MAX_DEPTH),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) idx_i (
    .clk       (clk),
    .rst       (rst),
    .depth_e   (depth_e),
    .ev_valid  (ev_valid),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .get_q     (get_idx),
    .get_n     (get_n),
    .fill_q    (fill),
    .fill_n    (fill_n),
    .full_q    (full),
    .drop      (drop)
  );

  txev_store #(
    .DEPTH (MAX_DEPTH),
    .IDX_W (IDX_W),
    .DW    (DW)
  ) store_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata ({ev_id, ev_ts, ev_mark}),
    .raddr (get_n),
    .rdata (rdata)
  );

  assign {rd_id, rd_ts, rd_mark} = rdata;

  txev_irq #(
    .CNT_W (CNT_W)
  ) irq_i (
    .clk       (clk),
    .rst       (rst),
    .depth_e   (depth_e),
    .wmark     (cfg_wmark),
    .fill_q    (fill),
    .fill_n    (fill_n),
    .drop      (drop),
    .clr_valid (clr_valid),
    .clr_mask  (clr_mask),
    .flags     (flags)
  );

  assign irq_full  = flags[FLG_FULL];
  assign irq_wmark = flags[FLG_WMARK];
  assign irq_lost  = flags[FLG_LOST];

  // element address: base plus two address units per element
  always_ff @(posedge clk) begin
    if (rst) rd_addr <= cfg_start;
    else     rd_addr <= cfg_start + ADDR_W'({get_n, 1'b0});
  end

endmodule

// File: rtl/txev_fifo_chk.sv
module txev_fifo_chk #(
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic              ack_valid,
  input logic              clr_valid,
  input logic [2:0]        clr_mask,
  input logic [CNT_W-1:0]  depth_e,
  input logic [CNT_W-1:0]  fill,
  input logic [IDX_W-1:0]  get_idx,
  input logic [ADDR_W-1:0] cfg_start,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              full,
  input logic              irq_full,
  input logic              irq_lost
);

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
    fill <= depth_e);

  p_full_level_r3: assert property (@(posedge clk) disable iff (rst)
    full == (fill == depth_e));

  p_drop_lost_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && full) |=> irq_lost);

  p_drop_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && full && !ack_valid) |=> $stable(fill));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ev_valid && !ack_valid) |=> ($stable(fill) && $stable(get_idx)));

  p_full_irq_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> irq_full);

  p_lost_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_lost && !(clr_valid && clr_mask[2])) |=> irq_lost);

  p_addr_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_addr == $past(cfg_start) + ADDR_W'({get_idx, 1'b0})));

endmodule

bind txev_fifo txev_fifo_chk #(
  .IDX_W  (IDX_W),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ev_valid  (ev_valid),
  .ack_valid (ack_valid),
  .clr_valid (clr_valid),
  .clr_mask  (clr_mask),
  .depth_e   (depth_e),
  .fill      (fill),
  .get_idx   (get_idx),
  .cfg_start (cfg_start),
  .rd_addr   (rd_addr),
  .full      (full),
  .irq_full  (irq_full),
  .irq_lost  (irq_lost)
);

// File: tb/txev_fifo_tb_top.sv
`timescale 1ns/1ps
module txev_fifo_tb_top;

  localparam int MAXD = 8;
  localparam int IW   = 3;
  localparam int CW   = 4;
  localparam int AW   = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg_depth = '0;
  logic [CW-1:0] cfg_wmark = '0;
  logic [AW-1:0] cfg_start = '0;
  logic          ev_valid = 1'b0;
  logic [28:0]   ev_id = '0;
  logic [15:0]   ev_ts = '0;
  logic [7:0]    ev_mark = '0;
  logic          ack_valid = 1'b0;
  logic [IW-1:0] ack_idx = '0;
  logic          clr_valid = 1'b0;
  logic [2:0]    clr_mask = '0;
  logic [28:0]   rd_id;
  logic [15:0]   rd_ts;
  logic [7:0]    rd_mark;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] fill;
  logic [IW-1:0] get_idx;
  logic          full, irq_full, irq_wmark, irq_lost;

  always #10 clk = ~clk;

  txev_fifo #(.MAX_DEPTH(MAXD), .ID_W(29), .TS_W(16), .MK_W(8), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_wmark(cfg_wmark),
    .cfg_start(cfg_start), .ev_valid(ev_valid), .ev_id(ev_id), .ev_ts(ev_ts),
    .ev_mark(ev_mark), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .rd_id(rd_id), .rd_ts(rd_ts),
    .rd_mark(rd_mark), .rd_addr(rd_addr), .fill(fill), .get_idx(get_idx),
    .full(full), .irq_full(irq_full), .irq_wmark(irq_wmark), .irq_lost(irq_lost)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  int m_fill, m_get, m_put, m_addr;
  bit m_ifull, m_iwm, m_ilost;
  longint m_id [MAXD];
  longint m_ts [MAXD];
  longint m_mk [MAXD];

  task automatic chk(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_depth(int d);
    if (d == 0) return 1;
    if (d > MAXD) return MAXD;
    return d;
  endfunction

  // arithmetic model of one rising edge, from the requirements
  task automatic model_edge();
    int d, k, freed, fill_n, a, wm;
    bit wr_ok, ack_ok, drop, set_f, set_w;
    d = eff_depth(int'(cfg_depth));
    a = int'(ack_idx);
    wr_ok = ev_valid && (m_fill < d);
    drop = ev_valid && !wr_ok;
    k = (a >= m_get) ? a - m_get : a + d - m_get;
    ack_ok = ack_valid && (a < d) && (k < m_fill);
    freed = ack_ok ? k + 1 : 0;
    fill_n = m_fill + (wr_ok ? 1 : 0) - freed;
    wm = int'(cfg_wmark);
    set_f = (fill_n == d) && (m_fill != d);
    set_w = (wm != 0) && (wm <= d) && (m_fill < wm) && (fill_n >= wm);
    if (wr_ok) begin
      m_id[m_put] = longint'(ev_id);
      m_ts[m_put] = longint'(ev_ts);
      m_mk[m_put] = longint'(ev_mark);
      m_put = (m_put + 1) % d;
    end
    if (ack_ok) m_get = (a + 1) % d;
    m_fill = fill_n;
    m_ifull = set_f || (m_ifull && !(clr_valid && clr_mask[0]));
    m_iwm   = set_w || (m_iwm   && !(clr_valid && clr_mask[1]));
    m_ilost = drop  || (m_ilost && !(clr_valid && clr_mask[2]));
    m_addr  = (int'(cfg_start) + 2 * m_get) % (1 << AW);
  endtask

  task automatic compare_all();
    int d;
    d = eff_depth(int'(cfg_depth));
    chk("R5 fill", longint'(fill), m_fill);
    chk("R2 get_idx", longint'(get_idx), m_get);
    chk("R3 full", longint'(full), (m_fill == d) ? 1 : 0);
    chk("R8 irq_full", longint'(irq_full), m_ifull);
    chk("R9 irq_wmark", longint'(irq_wmark), m_iwm);
    chk("R4 irq_lost", longint'(irq_lost), m_ilost);
    chk("R11 rd_addr", longint'(rd_addr), m_addr);
    if (m_fill > 0) begin
      chk("R1 rd_id", longint'(rd_id), m_id[m_get]);
      chk("R1 rd_ts", longint'(rd_ts), m_ts[m_get]);
      chk("R1 rd_mark", longint'(rd_mark), m_mk[m_get]);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(bit ev, bit ack, int aidx, bit clr, int cm);
    ev_valid  = ev;
    ev_id     = 29'($urandom);
    ev_ts     = 16'($urandom);
    ev_mark   = 8'($urandom);
    ack_valid = ack;
    ack_idx   = IW'(aidx);
    clr_valid = clr;
    clr_mask  = 3'(cm);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(int d, int wm, int st);
    rst = 1'b1;
    cfg_depth = CW'(d);
    cfg_wmark = CW'(wm);
    cfg_start = AW'(st);
    ev_valid = 0; ack_valid = 0; clr_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 fill", longint'(fill), 0);
    chk("R12 get_idx", longint'(get_idx), 0);
    chk("R12 full", longint'(full), 0);
    chk("R12 flags", longint'({irq_full, irq_wmark, irq_lost}), 0);
    chk("R12 rd_addr", longint'(rd_addr), st);
    m_fill = 0; m_get = 0; m_put = 0; m_addr = st;
    m_ifull = 0; m_iwm = 0; m_ilost = 0;
    rst = 1'b0;
  endtask

  task automatic run_cfg(int dcfg, int wm);
    int d;
    d = eff_depth(dcfg);
    do_reset(dcfg, wm, int'($urandom_range(0, 1000)));
    // fill past full: last events are dropped (R4), full flag rises (R8)
    for (int i = 0; i < d + 2; i++) step(1, 0, 0, 0, 0);
    // drop with a same-cycle valid acknowledge: event lost, ack applied (R4, R7)
    step(1, 1, m_get, 0, 0);
    // out-of-range index is ignored (R6)
    if (d < MAXD) step(0, 1, d, 0, 0);
    // write-one-to-clear of every flag (R10)
    step(0, 0, 0, 1, 7);
    // free everything by acknowledging the newest element (R5)
    if (m_fill > 0) step(0, 1, (m_get + m_fill - 1) % d, 0, 0);
    // ack on an empty store is ignored (R6)
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < 120; i++) begin
      if ($urandom_range(0, 15) == 0) cfg_start = AW'($urandom);
      step($urandom_range(0, 9) < 6, $urandom_range(0, 9) < 3,
           int'($urandom_range(0, MAXD - 1)), $urandom_range(0, 9) == 0,
           int'($urandom_range(0, 7)));
    end
  endtask

  initial begin
    @(negedge clk);
    for (int d = 1; d <= MAXD; d++) begin
      run_cfg(d, 0);
      run_cfg(d, 1);
      run_cfg(d, d / 2 + 1);
      run_cfg(d, d);
      run_cfg(d, d + 1);
    end
    // R2 clamping of out-of-range depth settings
    run_cfg(0, 1);
    run_cfg(12, 5);
    run_cfg(15, 8);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule